// File: doc/BRIEF.md
# UART Receive Line Status and Receive Queue

This block sits between a UART receive deserializer and the CPU-facing register file. Each time the deserializer finishes a character it raises a one-cycle strobe with the 8-bit character and three error tags: break, framing and parity. The block stores the character and its tags together in a 16-entry receive queue. It presents the oldest character to the CPU and assembles an 8-bit line status word.

The status word has a data-ready bit and an overrun bit. It also has three error bits that are sticky. An error tag is shown only once its own character has reached the head of the queue. Overrun is shown as soon as a character arrives while the queue is full. That character is thrown away.

A status read clears every error indication. A write to the status word is ignored. When the receiver-line-status interrupt is enabled, any set error indication drives the interrupt line.

Top module: `uart_rx_line_status`

## Requirements
- R1: Status bit 0 (data ready) is 1 from the cycle after a character is accepted until the cycle after the last stored character is popped, and 0 whenever the queue is empty.
- R2: The queue holds up to 16 characters in arrival order, and `rx_head` shows the oldest one. A pop removes it. A pop while the queue is empty changes nothing.
- R3: A character strobe while 16 characters are stored sets status bit 1 (overrun) in the next cycle. The character is discarded, and the stored characters and their order are unchanged. Filling the queue to exactly 16 does not set the bit.
- R4: Error tags map to status bit 2 (parity), bit 3 (framing) and bit 4 (break). A tag becomes visible in the second cycle after its character becomes the head, and never while the character is queued behind another one.
- R5: Once set, bits 4:1 stay set after the flagged character is popped, until a status read.
- R6: A status read clears bits 4:1 in the next cycle and leaves bit 0 unchanged. A character that is still at the head does not raise its tag again after the read.
- R7: If a status read and a new overrun, or a new head arrival carrying a tag, fall in the same cycle, the new indication is set after that cycle.
- R8: `rls_irq` is 1 exactly when `rls_ie` is 1 and any of status bits 4:1 is set.
- R9: A pulse on `lsr_wr` changes neither the status word nor the interrupt.
- R10: After reset the status word is 0x00 and `rls_irq` is 0. Status bits 7:5 always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_done | input | 1 | Character-complete strobe from the deserializer |
| rx_data | input | 8 | Received character |
| rx_brk | input | 1 | Break tag for the character |
| rx_frm | input | 1 | Framing error tag for the character |
| rx_par | input | 1 | Parity error tag for the character |
| rx_pop | input | 1 | Remove the head character |
| rx_head | output | 8 | Oldest stored character |
| lsr_rd | input | 1 | CPU read strobe of the status word |
| lsr_wr | input | 1 | CPU write strobe of the status word (ignored) |
| rls_ie | input | 1 | Receiver-line-status interrupt enable |
| lsr | output | 8 | Line status word |
| rls_irq | output | 1 | Receiver-line-status interrupt |

## Verification
A wrong queue pointer or a wrong count shows at `rx_head` on the next pop, when the scoreboard holds a different oldest character. It also shows at status bit 0 in the cycle after the queue should have become empty or non-empty. A broken head-arrival tracker shows up within two cycles of a pop or push. It either raises a tag early, for a character that is still queued behind another, or it raises a tag again after a read. A clear-versus-set priority error shows in the cycle right after a read that coincides with an overrun or a head arrival.

// File: rtl/uart_rls_pkg.sv
package uart_rls_pkg;
   typedef struct packed {
      logic brk;
      logic frm;
      logic par;
   } rx_err_t;

   localparam int ERR_W  = $bits(rx_err_t);
   localparam int STAT_W = 8;
   localparam int BIT_DR = 0;
   localparam int BIT_OV = 1;
   localparam int BIT_PE = 2;
endpackage

// File: rtl/rls_fifo.sv
module rls_fifo #(
   parameter int DEPTH = 16,
   parameter int WIDTH = 11
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             push,
   input  logic             pop,
   input  logic [WIDTH-1:0] wdata,
   output logic [WIDTH-1:0] rdata,
   output logic             empty,
   output logic             full,
   output logic             pop_ok
);
   localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int CW = $clog2(DEPTH + 1);

   logic [WIDTH-1:0] mem [DEPTH];
   logic [AW-1:0]    wr_ptr, rd_ptr, wr_nxt, rd_nxt;
   logic [CW-1:0]    level;
   logic             push_ok;

   initial begin : param_chk
      if (DEPTH < 2)  $fatal(1, "rls_fifo: DEPTH must be at least 2");
      if (WIDTH < 1)  $fatal(1, "rls_fifo: WIDTH must be positive");
   end

   assign empty   = (level == '0);
   assign full    = (level == CW'(DEPTH));
   assign push_ok = push && !full;
   assign pop_ok  = pop && !empty;
   assign rdata   = mem[rd_ptr];

   generate
      if ((DEPTH & (DEPTH - 1)) == 0) begin : g_pow2
         assign wr_nxt = wr_ptr + 1'b1;
         assign rd_nxt = rd_ptr + 1'b1;
      end else begin : g_wrap
         assign wr_nxt = (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
         assign rd_nxt = (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
      end

      for (genvar i = 0; i < DEPTH; i++) begin : g_slot
         always_ff @(posedge clk) begin
            if (push_ok && (wr_ptr == AW'(i))) mem[i] <= wdata;
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         level  <= '0;
      end else begin
         if (push_ok) wr_ptr <= wr_nxt;
         if (pop_ok)  rd_ptr <= rd_nxt;
         case ({push_ok, pop_ok})
            2'b10:   level <= level + 1'b1;
            2'b01:   level <= level - 1'b1;
            default: level <= level;
         endcase
      end
   end
endmodule

// File: rtl/rls_status.sv
module rls_status
   import uart_rls_pkg::*;
(
   input  logic    clk,
   input  logic    rst_n,
   input  logic    head_valid,
   input  rx_err_t head_tag,
   input  logic    head_pop,
   input  logic    ovr_evt,
   input  logic    clr_rd,
   output rx_err_t err_q,
   output logic    ovr_q
);
   logic    seen_q;
   logic    arrive;
   rx_err_t err_base;

   assign arrive   = head_valid && !seen_q;
   assign err_base = clr_rd ? rx_err_t'('0) : err_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         seen_q <= 1'b0;
         err_q  <= '0;
         ovr_q  <= 1'b0;
      end else begin
         if (head_pop)    seen_q <= 1'b0;
         else if (arrive) seen_q <= 1'b1;
         err_q <= err_base | (arrive ? head_tag : rx_err_t'('0));
         ovr_q <= (ovr_q && !clr_rd) || ovr_evt;
      end
   end
endmodule

// File: rtl/uart_rx_line_status.sv
module uart_rx_line_status
   import uart_rls_pkg::*;
#(
   parameter int DEPTH  = 16,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rx_done,
   input  logic [DATA_W-1:0] rx_data,
   input  logic              rx_brk,
   input  logic              rx_frm,
   input  logic              rx_par,
   input  logic              rx_pop,
   output logic [DATA_W-1:0] rx_head,
   input  logic              lsr_rd,
   input  logic              lsr_wr,
   input  logic              rls_ie,
   output logic [STAT_W-1:0] lsr,
   output logic              rls_irq
);
   localparam int WORD_W = DATA_W + ERR_W;

   logic [WORD_W-1:0] in_word, head_word;
   logic              fifo_empty, fifo_full, pop_ok;
   rx_err_t           in_tag, head_tag, err_q;
   logic              ovr_q;

   initial begin : param_chk
      if (DATA_W < 5 || DATA_W > 9) $fatal(1, "uart_rx_line_status: DATA_W out of range");
   end

   assign in_tag  = '{brk: rx_brk, frm: rx_frm, par: rx_par};
   assign in_word = {in_tag, rx_data};

   rls_fifo #(.DEPTH(DEPTH), .WIDTH(WORD_W)) u_fifo (
      .clk    (clk),
      .rst_n  (rst_n),
      .push   (rx_done),
      .pop    (rx_pop),
      .wdata  (in_word),
      .rdata  (head_word),
      .empty  (fifo_empty),
      .full   (fifo_full),
      .pop_ok (pop_ok)
   );

   assign head_tag = rx_err_t'(head_word[WORD_W-1:DATA_W]);
   assign rx_head  = head_word[DATA_W-1:0];

   rls_status u_status (
      .clk        (clk),
      .rst_n      (rst_n),
      .head_valid (!fifo_empty),
      .head_tag   (head_tag),
      .head_pop   (pop_ok),
      .ovr_evt    (rx_done && fifo_full),
      .clr_rd     (lsr_rd),
      .err_q      (err_q),
      .ovr_q      (ovr_q)
   );

   always_comb begin
      lsr          = '0;
      lsr[BIT_DR]  = !fifo_empty;
      lsr[BIT_OV]  = ovr_q;
      lsr[BIT_PE+2:BIT_PE] = {err_q.brk, err_q.frm, err_q.par};
   end

   assign rls_irq = rls_ie && (ovr_q || (|err_q));
endmodule

// File: rtl/rls_chk.sv
module rls_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       rx_done,
   input logic       rx_pop,
   input logic       lsr_rd,
   input logic       lsr_wr,
   input logic       rls_ie,
   input logic [7:0] lsr,
   input logic       rls_irq,
   input logic       fifo_full,
   input logic       fifo_empty
);
   // R1
   dr_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rx_done && !fifo_full |=> lsr[0]);

   // R3
   ovr_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rx_done && fifo_full |=> lsr[1]);

   // R3
   ovr_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rx_done && fifo_full && !rx_pop |=> fifo_full);

   // R5
   sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (|($past(lsr[4:1]) & ~lsr[4:1])) |-> $past(lsr_rd));

   // R6
   rd_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      lsr_rd && !rx_done && fifo_empty |=> (lsr[4:1] == 4'b0000));

   // R8
   irq_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !rls_ie |-> !rls_irq);

   // R9
   wr_null_chk: assert property (@(posedge clk) disable iff (!rst_n)
      lsr_wr && !lsr_rd && !rx_done && fifo_empty |=> (lsr == $past(lsr)));
endmodule

bind uart_rx_line_status rls_chk u_rls_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .rx_done    (rx_done),
   .rx_pop     (rx_pop),
   .lsr_rd     (lsr_rd),
   .lsr_wr     (lsr_wr),
   .rls_ie     (rls_ie),
   .lsr        (lsr),
   .rls_irq    (rls_irq),
   .fifo_full  (fifo_full),
   .fifo_empty (fifo_empty)
);

// File: tb/uart_rx_line_status_test.sv
`timescale 1ns/1ps
module uart_rx_line_status_test;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       rx_done = 1'b0, rx_brk = 1'b0, rx_frm = 1'b0, rx_par = 1'b0;
   logic [7:0] rx_data = 8'h00;
   logic       rx_pop = 1'b0, lsr_rd = 1'b0, lsr_wr = 1'b0, rls_ie = 1'b0;
   logic [7:0] rx_head, lsr;
   logic       rls_irq;

   int         checks = 0;
   int         errors = 0;
   logic [7:0] sb_q[$];
   logic [7:0] rv;

   always #2.5 clk = ~clk;

   uart_rx_line_status uut (
      .clk(clk), .rst_n(rst_n), .rx_done(rx_done), .rx_data(rx_data),
      .rx_brk(rx_brk), .rx_frm(rx_frm), .rx_par(rx_par), .rx_pop(rx_pop),
      .rx_head(rx_head), .lsr_rd(lsr_rd), .lsr_wr(lsr_wr), .rls_ie(rls_ie),
      .lsr(lsr), .rls_irq(rls_irq)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic tick();
      @(negedge clk);
   endtask

   // driver: presents one character and records what should be stored
   task automatic drive_char(input logic [7:0] d, input logic b, input logic f, input logic p);
      rx_data = d; rx_brk = b; rx_frm = f; rx_par = p; rx_done = 1'b1;
      tick();
      rx_done = 1'b0; rx_brk = 1'b0; rx_frm = 1'b0; rx_par = 1'b0;
      if (sb_q.size() < 16) sb_q.push_back(d);
   endtask

   // monitor: compares the head against the scoreboard, then pops it
   task automatic pop_cmp(input string req);
      logic [7:0] exp;
      exp = sb_q.pop_front();
      check(req, rx_head, exp);
      rx_pop = 1'b1;
      tick();
      rx_pop = 1'b0;
   endtask

   task automatic read_lsr(output logic [7:0] v);
      v = lsr;
      lsr_rd = 1'b1;
      tick();
      lsr_rd = 1'b0;
   endtask

   task automatic fill_full(input logic [7:0] base);
      for (int i = 0; i < 16; i++) drive_char(base + 8'(i * 7), 1'b0, 1'b0, 1'b0);
   endtask

   task automatic drain(input string req);
      while (sb_q.size() > 0) pop_cmp(req);
   endtask

   initial begin
      repeat (3) tick();
      rst_n = 1'b1;
      tick();
      // R10 reset state
      check("R10 reset lsr", lsr, 8'h00);
      check("R10 reset irq", rls_irq, 1'b0);

      // R1 / R2 basic push and pop
      drive_char(8'h41, 0, 0, 0);
      check("R1 data ready after push", lsr, 8'h01);
      pop_cmp("R2 head order");
      check("R1 data ready cleared", lsr, 8'h00);
      rx_pop = 1'b1; tick(); rx_pop = 1'b0;
      check("R2 pop on empty", lsr, 8'h00);
      drive_char(8'h55, 0, 0, 0);
      check("R2 head after empty pop", rx_head, 8'h55);
      pop_cmp("R2 head after empty pop");

      // R4 / R5 / R6 / R8 parity behind a clean char
      rls_ie = 1'b1;
      drive_char(8'h10, 0, 0, 0);
      drive_char(8'h20, 0, 0, 1);
      tick();
      check("R4 tag hidden behind head", lsr, 8'h01);
      check("R8 irq idle", rls_irq, 1'b0);
      pop_cmp("R2 head order");
      tick();
      check("R4 parity at head", lsr, 8'h05);
      check("R8 irq on parity", rls_irq, 1'b1);
      pop_cmp("R2 head order");
      check("R5 sticky after pop", lsr, 8'h04);
      read_lsr(rv);
      check("R6 read value", rv, 8'h04);
      check("R6 read clears", lsr, 8'h00);
      check("R8 irq cleared", rls_irq, 1'b0);

      // R4 framing, R6 no re-raise
      drive_char(8'h33, 0, 1, 0);
      tick();
      check("R4 framing bit3", lsr, 8'h09);
      read_lsr(rv);
      check("R6 keeps data ready, no re-raise", lsr, 8'h01);
      tick();
      check("R6 still no re-raise", lsr, 8'h01);
      pop_cmp("R2 head order");

      // R4 break, R9 write ignored
      drive_char(8'h44, 1, 0, 0);
      tick();
      check("R4 break bit4", lsr, 8'h11);
      lsr_wr = 1'b1; tick(); lsr_wr = 1'b0;
      check("R9 write ignored lsr", lsr, 8'h11);
      check("R9 write ignored irq", rls_irq, 1'b1);
      read_lsr(rv);
      pop_cmp("R2 head order");
      lsr_wr = 1'b1; tick(); lsr_wr = 1'b0;
      check("R9 write on clear status", lsr, 8'h00);

      // R3 overrun
      fill_full(8'h01);
      check("R3 exactly full no overrun", lsr, 8'h01);
      drive_char(8'hEE, 0, 0, 0);
      check("R3 overrun set", lsr, 8'h03);
      check("R8 irq on overrun", rls_irq, 1'b1);
      drain("R3 stored chars intact");
      check("R5 overrun sticky when empty", lsr, 8'h02);
      read_lsr(rv);
      check("R6 overrun cleared", lsr, 8'h00);

      // R7 read coinciding with overrun
      fill_full(8'h80);
      rx_data = 8'h99; rx_done = 1'b1; lsr_rd = 1'b1;
      tick();
      rx_done = 1'b0; lsr_rd = 1'b0;
      check("R7 overrun wins over read", lsr, 8'h03);
      read_lsr(rv);
      check("R6 overrun cleared again", lsr, 8'h01);
      drain("R3 stored chars intact");

      // R7 read coinciding with head arrival of a parity char
      drive_char(8'h5A, 0, 0, 1);
      read_lsr(rv);
      check("R7 arrival wins over read", lsr, 8'h05);
      read_lsr(rv);
      check("R6 parity cleared", lsr, 8'h01);
      pop_cmp("R2 head order");

      // R8 masked interrupt
      rls_ie = 1'b0;
      fill_full(8'h03);
      drive_char(8'hAB, 0, 0, 0);
      check("R8 masked overrun bit", lsr[1], 1'b1);
      check("R8 masked irq", rls_irq, 1'b0);
      rls_ie = 1'b1;
      #1;
      check("R8 irq when enabled", rls_irq, 1'b1);
      tick();
      read_lsr(rv);
      drain("R2 head order");
      check("R1 empty at end", lsr, 8'h00);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog actual running expected finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule